// File: doc/BRIEF.md
# Watchdog Register Front End with Magic Unlock

This block is the host-facing register layer of a two-stage watchdog. It decodes two address spaces on a simple synchronous bus with address, write data, access size and write and read strobes. The memory window holds the two preload values and a reload/status word. The configuration space holds a 16-bit mode register and an 8-bit lock register. The block drives configuration outputs, a start pulse, a reload pulse and a flag-clear pulse to a separate countdown core.

Writes that change the preloads or touch the reload word are protected. Two key bytes must first arrive in order at the reload offset. Each unlock is used up by the next half-word or word write that is not a key. A set-once lock bit freezes the enable, lock and free-run settings until reset. A previous-reboot flag is set by the core. It survives the normal reset and is cleared only by power-on reset or by a protected write.

Top module: `wdt_regfront`

## Requirements
- R1: After `rst_n` the outputs are: reboot enabled, slow scale, interrupt type 0, free-run 0, enable 0, lock 0, both preloads 0xFFFFF, unlock state idle. `rst_n` leaves the previous-reboot flag unchanged. `por_n` clears the flag.
- R2: In the memory window (`bus_cfg`=0), a write of 0x80 to offset 0x0C moves the unlock state to armed from any state. A following write of 0x86 to 0x0C while armed opens the unlock. This holds at any access size: 0 byte, 1 half-word, 2 word. In the armed state, other writes leave it armed.
- R3: While open, a word write to offset 0x00 loads preload 1 with data bits 19:0. A word write to offset 0x04 loads preload 2 the same way.
- R4: While open, a half-word write to 0x0C with bit 8 set gives a one-cycle `wd_reload` pulse. With bit 9 or bit 12 set, it clears the previous-reboot flag and gives a one-cycle `wd_flag_clear` pulse.
- R5: A half-word or word non-key write acts only when the unlock is open. It always returns the unlock state to idle. Without an unlock it changes nothing.
- R6: A non-key byte write in the memory window neither acts nor uses up an open unlock.
- R7: A half-word read of memory offset 0x0C returns 0x1200 when the previous-reboot flag is set and 0 otherwise. Every other memory read returns 0.
- R8: Configuration register, half-word at config offset 0x60: bit 5 = 1 disables reboot, bit 2 = 1 selects the fast scale, and bits 1:0 give the interrupt type (0 IRQ, 2 SMI, 3 off). It reads back in that layout. Accesses of another size are ignored.
- R9: Lock register, byte at config offset 0x68: bit 0 lock, bit 1 enable, bit 2 free-run, read back the same way. Once lock is 1, writes to it are ignored until `rst_n`.
- R10: A 0-to-1 change of enable gives a one-cycle `wd_start` pulse. Writing enable as 0 drops `wd_enable`.
- R11: A `reboot_seen` pulse sets the previous-reboot flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| por_n | input | 1 | Asynchronous active-low power-on reset for the reboot flag |
| bus_cfg | input | 1 | 1 selects configuration space, 0 the memory window |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_size | input | 2 | 0 byte, 1 half-word, 2 word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, same cycle as `bus_rd` |
| reboot_seen | input | 1 | Core pulse: stage-two expiry caused a reboot |
| wd_enable | output | 1 | Countdown enabled |
| wd_start | output | 1 | One-cycle pulse: begin stage 1 |
| wd_free_run | output | 1 | Restart after stage-two expiry |
| wd_reboot_en | output | 1 | Reboot on stage-two expiry |
| wd_fast_scale | output | 1 | Fast decrement scale |
| wd_int_type | output | 2 | Stage-one interrupt type |
| wd_preload1 | output | 20 | Stage-one preload |
| wd_preload2 | output | 20 | Stage-two preload |
| wd_reload | output | 1 | One-cycle keep-alive pulse |
| wd_flag_clear | output | 1 | One-cycle pulse: reboot flag cleared |

## Verification
Some properties are checked on every cycle:
- the unlock never jumps from idle to open;
- a grant always closes the unlock;
- preloads and the reload pulse change only out of the open state;
- a start pulse needs a rising enable;
- a set lock keeps enable and free-run still.

Other behaviours show only in bench scenarios:
- the exact bit layouts;
- the read values;
- a byte write leaving an unlock open;
- the flag surviving `rst_n`.

The bench sweeps every config and lock value to cover them.

// File: rtl/wdt_rf_pkg.sv
package wdt_rf_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_ARMED = 2'd1,
    UL_OPEN  = 2'd2
  } ul_state_e;

  // Memory window offsets
  localparam logic [7:0] OFS_PRE1  = 8'h00;
  localparam logic [7:0] OFS_PRE2  = 8'h04;
  localparam logic [7:0] OFS_KICK  = 8'h0C;
  // Configuration space offsets
  localparam logic [7:0] OFS_MODE  = 8'h60;
  localparam logic [7:0] OFS_LOCK  = 8'h68;

  // Bit positions in the reload/status word
  localparam int BIT_KICK    = 8;
  localparam int BIT_CLR_A   = 9;
  localparam int BIT_CLR_B   = 12;

  // Bit positions in the mode register
  localparam int BIT_NOBOOT  = 5;
  localparam int BIT_FAST    = 2;

  // Bit positions in the lock register
  localparam int BIT_LOCK    = 0;
  localparam int BIT_EN      = 1;
  localparam int BIT_FREE    = 2;

  function automatic logic [31:0] size_trim(input logic [31:0] d, input logic [1:0] sz);
    logic [31:0] r;
    case (sz)
      SZ_BYTE: r = {24'd0, d[7:0]};
      SZ_HALF: r = {16'd0, d[15:0]};
      default: r = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wdt_rf_unlock.sv
module wdt_rf_unlock
  import wdt_rf_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter int                DATA_W  = 32,
  parameter logic [ADDR_W-1:0] KEY_OFS = 8'h0C,
  parameter logic [DATA_W-1:0] KEY1    = 32'h80,
  parameter logic [DATA_W-1:0] KEY2    = 32'h86
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mem,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        size,
  output logic              grant,
  output logic              open,
  output logic              armed
);

  ul_state_e   state_q, state_d;
  logic [DATA_W-1:0] data_sz;
  logic        at_key, key1_hit, key2_hit, plain_wr;

  always_comb begin
    data_sz  = size_trim(wdata, size);
    at_key   = wr_mem && (addr == KEY_OFS);
    key1_hit = at_key && (data_sz == KEY1);
    key2_hit = at_key && (data_sz == KEY2) && (state_q == UL_ARMED);
    // byte writes that are not keys are invisible to the unlock
    plain_wr = wr_mem && !key1_hit && !key2_hit && (size != SZ_BYTE);
    grant    = plain_wr && (state_q == UL_OPEN);
  end

  always_comb begin
    state_d = state_q;
    if (key1_hit)      state_d = UL_ARMED;
    else if (key2_hit) state_d = UL_OPEN;
    else if (grant)    state_d = UL_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= UL_IDLE;
    else        state_q <= state_d;
  end

  assign open  = (state_q == UL_OPEN);
  assign armed = (state_q == UL_ARMED);

endmodule

// File: rtl/wdt_rf_mem.sv
module wdt_rf_mem
  import wdt_rf_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int PRELOAD_W = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 por_n,
  input  logic                 grant,
  input  logic                 rd_mem,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [1:0]           size,
  input  logic                 reboot_seen,
  output logic [PRELOAD_W-1:0] preload1,
  output logic [PRELOAD_W-1:0] preload2,
  output logic                 reload,
  output logic                 flag_clear,
  output logic [DATA_W-1:0]    rdata
);

  localparam logic [PRELOAD_W-1:0] PRE_RST = {PRELOAD_W{1'b1}};
  localparam logic [DATA_W-1:0]    FLAG_RD = DATA_W'((1 << BIT_CLR_A) | (1 << BIT_CLR_B));

  logic [PRELOAD_W-1:0] pre1_q, pre2_q;
  logic                 pre1_en, pre2_en;
  logic                 kick_wr;
  logic                 reload_d, reload_q, clr_d, clr_q;
  logic                 flag_q, flag_d;

  always_comb begin
    pre1_en  = grant && (size == SZ_WORD) && (addr == ADDR_W'(OFS_PRE1));
    pre2_en  = grant && (size == SZ_WORD) && (addr == ADDR_W'(OFS_PRE2));
    kick_wr  = grant && (size == SZ_HALF) && (addr == ADDR_W'(OFS_KICK));
    reload_d = kick_wr && wdata[BIT_KICK];
    clr_d    = kick_wr && (wdata[BIT_CLR_A] || wdata[BIT_CLR_B]);
    flag_d   = flag_q;
    if (clr_d)       flag_d = 1'b0;
    if (reboot_seen) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre1_q <= PRE_RST;
    end else if (pre1_en) begin
      pre1_q <= wdata[PRELOAD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre2_q <= PRE_RST;
    end else if (pre2_en) begin
      pre2_q <= wdata[PRELOAD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      reload_q <= reload_d;
      clr_q    <= clr_d;
    end
  end

  // reboot history lives on the power-on domain only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_comb begin
    rdata = '0;
    if (rd_mem && (size == SZ_HALF) && (addr == ADDR_W'(OFS_KICK)) && flag_q)
      rdata = FLAG_RD;
  end

  assign preload1   = pre1_q;
  assign preload2   = pre2_q;
  assign reload     = reload_q;
  assign flag_clear = clr_q;

endmodule

// File: rtl/wdt_rf_cfg.sv
module wdt_rf_cfg
  import wdt_rf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cfg,
  input  logic              rd_cfg,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        size,
  output logic              enable,
  output logic              start,
  output logic              free_run,
  output logic              locked,
  output logic              reboot_en,
  output logic              fast_scale,
  output logic [1:0]        int_type,
  output logic [DATA_W-1:0] rdata
);

  logic       mode_wr, lock_wr;
  logic       noboot_q, fast_q;
  logic [1:0] itype_q;
  logic       en_q, en_d, free_q, free_d, lock_q, lock_d, start_d, start_q;

  always_comb begin
    mode_wr = wr_cfg && (size == SZ_HALF) && (addr == ADDR_W'(OFS_MODE));
    lock_wr = wr_cfg && (size == SZ_BYTE) && (addr == ADDR_W'(OFS_LOCK)) && !lock_q;
    en_d    = en_q;
    free_d  = free_q;
    lock_d  = lock_q;
    start_d = 1'b0;
    if (lock_wr) begin
      en_d    = wdata[BIT_EN];
      free_d  = wdata[BIT_FREE];
      lock_d  = wdata[BIT_LOCK];
      start_d = wdata[BIT_EN] && !en_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      noboot_q <= 1'b0;
      fast_q   <= 1'b0;
      itype_q  <= 2'd0;
    end else if (mode_wr) begin
      noboot_q <= wdata[BIT_NOBOOT];
      fast_q   <= wdata[BIT_FAST];
      itype_q  <= wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      free_q  <= 1'b0;
      lock_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      free_q  <= free_d;
      lock_q  <= lock_d;
      start_q <= start_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_cfg && (size == SZ_HALF) && (addr == ADDR_W'(OFS_MODE))) begin
      rdata[BIT_NOBOOT] = noboot_q;
      rdata[BIT_FAST]   = fast_q;
      rdata[1:0]        = itype_q;
    end else if (rd_cfg && (size == SZ_BYTE) && (addr == ADDR_W'(OFS_LOCK))) begin
      rdata[BIT_LOCK] = lock_q;
      rdata[BIT_EN]   = en_q;
      rdata[BIT_FREE] = free_q;
    end
  end

  assign enable     = en_q;
  assign start      = start_q;
  assign free_run   = free_q;
  assign locked     = lock_q;
  assign reboot_en  = !noboot_q;
  assign fast_scale = fast_q;
  assign int_type   = itype_q;

endmodule

// File: rtl/wdt_regfront.sv
module wdt_regfront
  import wdt_rf_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int PRELOAD_W = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 por_n,
  input  logic                 bus_cfg,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [1:0]           bus_size,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 reboot_seen,
  output logic                 wd_enable,
  output logic                 wd_start,
  output logic                 wd_free_run,
  output logic                 wd_reboot_en,
  output logic                 wd_fast_scale,
  output logic [1:0]           wd_int_type,
  output logic [PRELOAD_W-1:0] wd_preload1,
  output logic [PRELOAD_W-1:0] wd_preload2,
  output logic                 wd_reload,
  output logic                 wd_flag_clear
);

  logic              wr_mem, rd_mem, wr_cfg, rd_cfg;
  logic              ul_grant, ul_open, ul_armed, locked;
  logic [DATA_W-1:0] mem_rdata, cfg_rdata;

  assign wr_mem = bus_wr && !bus_cfg;
  assign rd_mem = bus_rd && !bus_cfg;
  assign wr_cfg = bus_wr &&  bus_cfg;
  assign rd_cfg = bus_rd &&  bus_cfg;

  wdt_rf_unlock #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .KEY_OFS (ADDR_W'(OFS_KICK)),
    .KEY1    (DATA_W'(32'h80)),
    .KEY2    (DATA_W'(32'h86))
  ) u_unlock (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_mem (wr_mem),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .size   (bus_size),
    .grant  (ul_grant),
    .open   (ul_open),
    .armed  (ul_armed)
  );

  wdt_rf_mem #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PRELOAD_W (PRELOAD_W)
  ) u_mem (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_n       (por_n),
    .grant       (ul_grant),
    .rd_mem      (rd_mem),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .size        (bus_size),
    .reboot_seen (reboot_seen),
    .preload1    (wd_preload1),
    .preload2    (wd_preload2),
    .reload      (wd_reload),
    .flag_clear  (wd_flag_clear),
    .rdata       (mem_rdata)
  );

  wdt_rf_cfg #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_cfg     (wr_cfg),
    .rd_cfg     (rd_cfg),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .size       (bus_size),
    .enable     (wd_enable),
    .start      (wd_start),
    .free_run   (wd_free_run),
    .locked     (locked),
    .reboot_en  (wd_reboot_en),
    .fast_scale (wd_fast_scale),
    .int_type   (wd_int_type),
    .rdata      (cfg_rdata)
  );

  assign bus_rdata = mem_rdata | cfg_rdata;

endmodule

// File: rtl/wdt_regfront_chk.sv
module wdt_regfront_chk #(
  parameter int PRELOAD_W = 20
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ul_open,
  input logic                 ul_armed,
  input logic                 ul_grant,
  input logic                 locked,
  input logic                 wd_enable,
  input logic                 wd_start,
  input logic                 wd_free_run,
  input logic [PRELOAD_W-1:0] wd_preload1,
  input logic [PRELOAD_W-1:0] wd_preload2,
  input logic                 wd_reload
);

  a_r2_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (!ul_open && !ul_armed) |=> !ul_open);

  a_r3_preload_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(wd_preload1) || !$stable(wd_preload2)) |-> $past(ul_open));

  a_r4_reload_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reload |-> $past(ul_open));

  a_r4_reload_single: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reload |=> !wd_reload);

  a_r5_grant_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    ul_grant |=> !ul_open);

  a_r9_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> (locked && $stable(wd_enable) && $stable(wd_free_run)));

  a_r10_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    wd_start |-> (wd_enable && !$past(wd_enable)));

endmodule

bind wdt_regfront wdt_regfront_chk #(.PRELOAD_W(PRELOAD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ul_open     (ul_open),
  .ul_armed    (ul_armed),
  .ul_grant    (ul_grant),
  .locked      (locked),
  .wd_enable   (wd_enable),
  .wd_start    (wd_start),
  .wd_free_run (wd_free_run),
  .wd_preload1 (wd_preload1),
  .wd_preload2 (wd_preload2),
  .wd_reload   (wd_reload)
);

// File: tb/wdt_regfront_tb.sv
module wdt_regfront_tb;

  logic        clk = 1'b0;
  logic        rst_n, por_n, bus_cfg, bus_wr, bus_rd, reboot_seen;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  bus_size;
  logic        wd_enable, wd_start, wd_free_run, wd_reboot_en, wd_fast_scale;
  logic [1:0]  wd_int_type;
  logic [19:0] wd_preload1, wd_preload2;
  logic        wd_reload, wd_flag_clear;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  wdt_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_cfg(bus_cfg),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_size(bus_size),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .reboot_seen(reboot_seen), .wd_enable(wd_enable), .wd_start(wd_start),
    .wd_free_run(wd_free_run), .wd_reboot_en(wd_reboot_en),
    .wd_fast_scale(wd_fast_scale), .wd_int_type(wd_int_type),
    .wd_preload1(wd_preload1), .wd_preload2(wd_preload2),
    .wd_reload(wd_reload), .wd_flag_clear(wd_flag_clear)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic with_por);
    @(negedge clk);
    rst_n = 1'b0;
    if (with_por) por_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    por_n = 1'b1;
    @(negedge clk);
  endtask

  // drive at negedge, registered effect visible at the following negedge
  task automatic wr(input logic cfg, input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
    bus_cfg = cfg; bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic cfg, input logic [7:0] a, input logic [1:0] sz, output logic [31:0] d);
    bus_cfg = cfg; bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic unlock();
    wr(1'b0, 8'h0C, 32'h80, 2'd0);
    wr(1'b0, 8'h0C, 32'h86, 2'd1);
  endtask

  task automatic pulse_reboot();
    reboot_seen = 1'b1;
    @(negedge clk);
    reboot_seen = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; por_n = 1'b0; bus_cfg = 1'b0; bus_addr = '0; bus_wdata = '0;
    bus_size = 2'd0; bus_wr = 1'b0; bus_rd = 1'b0; reboot_seen = 1'b0;
    do_reset(1'b1);

    // R1 reset state
    check("R1 reboot_en", 32'(wd_reboot_en), 32'd1);
    check("R1 fast", 32'(wd_fast_scale), 32'd0);
    check("R1 itype", 32'(wd_int_type), 32'd0);
    check("R1 en/free", {30'd0, wd_enable, wd_free_run}, 32'd0);
    check("R1 preload1", 32'(wd_preload1), 32'hFFFFF);
    check("R1 preload2", 32'(wd_preload2), 32'hFFFFF);
    rd(1'b1, 8'h68, 2'd0, r); check("R1 lock reg", r, 32'd0);
    rd(1'b0, 8'h0C, 2'd1, r); check("R7 flag idle", r, 32'd0);

    // R5 no unlock: ignored
    wr(1'b0, 8'h0C, 32'h0100, 2'd1); check("R5 no reload w/o unlock", 32'(wd_reload), 32'd0);
    wr(1'b0, 8'h00, 32'h12345, 2'd2); check("R5 preload w/o unlock", 32'(wd_preload1), 32'hFFFFF);

    // R3 load and R5 consume
    unlock();
    wr(1'b0, 8'h00, 32'hABC12345, 2'd2); check("R3 preload1", 32'(wd_preload1), 32'h12345);
    wr(1'b0, 8'h04, 32'h55555, 2'd2); check("R5 consumed", 32'(wd_preload2), 32'hFFFFF);
    unlock();
    wr(1'b0, 8'h04, 32'hFFF00001, 2'd2); check("R3 preload2", 32'(wd_preload2), 32'h00001);

    // R6 byte write leaves unlock open
    unlock();
    wr(1'b0, 8'h00, 32'h33, 2'd0); check("R6 byte no act", 32'(wd_preload1), 32'h12345);
    wr(1'b0, 8'h00, 32'h777, 2'd2); check("R6 still open", 32'(wd_preload1), 32'h00777);

    // R2 ordering
    wr(1'b0, 8'h0C, 32'h86, 2'd1);
    wr(1'b0, 8'h00, 32'h111, 2'd2); check("R2 second key alone", 32'(wd_preload1), 32'h00777);
    wr(1'b0, 8'h0C, 32'h80, 2'd2); wr(1'b0, 8'h0C, 32'h80, 2'd0); wr(1'b0, 8'h0C, 32'h86, 2'd0);
    wr(1'b0, 8'h00, 32'h222, 2'd2); check("R2 repeat first key", 32'(wd_preload1), 32'h00222);
    wr(1'b0, 8'h0C, 32'h80, 2'd1); wr(1'b0, 8'h08, 32'h5, 2'd1); wr(1'b0, 8'h0C, 32'h86, 2'd1);
    wr(1'b0, 8'h04, 32'h333, 2'd2); check("R2 armed holds", 32'(wd_preload2), 32'h00333);
    unlock(); wr(1'b0, 8'h0C, 32'h80, 2'd1);
    wr(1'b0, 8'h00, 32'h444, 2'd2); check("R2 rearm from open", 32'(wd_preload1), 32'h00222);

    // R11 / R4 / R7 flag and reload
    pulse_reboot();
    rd(1'b0, 8'h0C, 2'd1, r); check("R11 flag set", r, 32'h1200);
    rd(1'b0, 8'h0C, 2'd2, r); check("R7 word read zero", r, 32'd0);
    rd(1'b0, 8'h00, 2'd2, r); check("R7 other offset zero", r, 32'd0);
    unlock();
    wr(1'b0, 8'h0C, 32'h0100, 2'd1);
    check("R4 reload pulse", 32'(wd_reload), 32'd1);
    check("R4 no clear", 32'(wd_flag_clear), 32'd0);
    @(negedge clk); check("R4 reload one cycle", 32'(wd_reload), 32'd0);
    rd(1'b0, 8'h0C, 2'd1, r); check("R4 flag kept", r, 32'h1200);
    unlock();
    wr(1'b0, 8'h0C, 32'h1000, 2'd1);
    check("R4 clear pulse b12", 32'(wd_flag_clear), 32'd1);
    rd(1'b0, 8'h0C, 2'd1, r); check("R4 cleared b12", r, 32'd0);
    pulse_reboot(); unlock();
    wr(1'b0, 8'h0C, 32'h0200, 2'd1);
    rd(1'b0, 8'h0C, 2'd1, r); check("R4 cleared b9", r, 32'd0);

    // R1 flag across rst_n and por_n
    pulse_reboot();
    do_reset(1'b0);
    rd(1'b0, 8'h0C, 2'd1, r); check("R1 flag survives rst_n", r, 32'h1200);
    do_reset(1'b1);
    rd(1'b0, 8'h0C, 2'd1, r); check("R1 flag cleared by por_n", r, 32'd0);

    // R8 mode register sweep
    for (int v = 0; v < 64; v++) begin
      wr(1'b1, 8'h60, 32'(v), 2'd1);
      check("R8 reboot_en", 32'(wd_reboot_en), 32'(((v >> 5) & 1) ^ 1));
      check("R8 fast", 32'(wd_fast_scale), 32'((v >> 2) & 1));
      check("R8 itype", 32'(wd_int_type), 32'(v & 3));
      rd(1'b1, 8'h60, 2'd1, r); check("R8 readback", r, 32'(v & 32'h27));
    end
    wr(1'b1, 8'h60, 32'h0, 2'd0);
    check("R8 byte ignored", {29'd0, wd_reboot_en, wd_int_type}, 32'h3);

    // R9 / R10 lock register sweep
    for (int v = 0; v < 8; v++) begin
      do_reset(1'b0);
      wr(1'b1, 8'h68, 32'(v), 2'd0);
      check("R10 start pulse", 32'(wd_start), 32'((v >> 1) & 1));
      check("R9 enable", 32'(wd_enable), 32'((v >> 1) & 1));
      check("R9 free", 32'(wd_free_run), 32'((v >> 2) & 1));
      rd(1'b1, 8'h68, 2'd0, r); check("R9 readback", r, 32'(v));
      wr(1'b1, 8'h68, 32'h6, 2'd0);
      if ((v & 1) != 0) begin
        check("R9 locked enable", 32'(wd_enable), 32'((v >> 1) & 1));
        check("R9 locked free", 32'(wd_free_run), 32'((v >> 2) & 1));
        check("R10 no start locked", 32'(wd_start), 32'd0);
      end else begin
        check("R10 start on rise", 32'(wd_start), 32'(((v >> 1) & 1) ^ 1));
        wr(1'b1, 8'h68, 32'h0, 2'd0);
        check("R10 stop", 32'(wd_enable), 32'd0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule